// File: doc/BRIEF.md
# OFDM Frequency-Domain Symbol Builder

This block turns a serial payload bit stream into one 64-bin frequency-domain OFDM symbol at a time, ready to feed an inverse FFT. Bits arrive one per beat on a valid/ready handshake. Each group of 96 bits is held until the output side is free. The block then walks the 64 bins in ascending order and gives one complex sample per bin. Data bins carry Gray-coded QPSK points. Seven pilot bins carry BPSK chips that follow the length-7 Barker code. DC and a band of guard bins carry zero.

Input and output are decoupled by one symbol of storage. A new symbol can be collected while the previous one drains. The input stalls only when a full symbol is already waiting and the output is still busy or held back. A start-of-symbol flag marks bin 0 so that the downstream transform can align its frames.

Top module: `ofdm_sym_builder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Exactly 96 accepted bits make one symbol. When 96 bits are held and the previous symbol has not finished leaving, `in_ready` stays 0.
- R3: A symbol leaves as 64 accepted beats for bins 0,1,…,63 in that order. `out_sos` is 1 only on the bin-0 beat.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_i`, `out_q` and `out_sos` hold their values, and no bin is skipped or repeated.
- R5: A data bin with bit pair (f,s), where f is the earlier received bit, gives 00→(+A,+A), 01→(−A,+A), 11→(−A,−A), 10→(+A,−A). A is `AMP` (default 5793). Samples are 16-bit two's complement.
- R6: Data bins are every bin except 0, the guard bins and the pilot bins. There are 48 of them. Taken in ascending bin order, they use the 48 bit pairs in arrival order.
- R7: Pilot bins are 4, 12, 20, 26, 38, 46 and 54. In that order they carry the chips +1,+1,+1,−1,−1,+1,−1 as (±A, 0).
- R8: Bin 0 (DC) and guard bins 28 to 35 give (0, 0).
- R9: A symbol sent while the previous one is still leaving is kept intact. It is output right after the previous one, with none of its bits lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload bit is offered |
| in_bit | input | 1 | Payload bit |
| in_ready | output | 1 | Block accepts the offered bit |
| out_valid | output | 1 | A bin sample is presented |
| out_ready | input | 1 | Downstream takes the sample |
| out_i | output | 16 | Real part, signed |
| out_q | output | 16 | Imaginary part, signed |
| out_sos | output | 1 | Sample is bin 0 of a symbol |

## Verification
The mapping is tried with four payloads:
- An all-zero payload and an all-one payload each put one constellation point on every data bin. Any sign fault shows there, and the pilots stand out against a uniform background.
- A payload cycling through 00, 01, 11, 10 visits all four Gray points in turn. This separates a swapped bit order within a pair from a wrong Gray table.
- A pseudo-random payload run with irregular output stalls shows any error in the data-bin ordinal, and any skipped or repeated bin under backpressure.

A last scenario holds the output low while two symbols are pushed. This shows that the input stalls and that the second symbol follows the first unchanged.

// File: rtl/ofdm_sym_pkg.sv
package ofdm_sym_pkg;

  // Sign decisions of one QPSK point (1 = negative axis value)
  typedef struct packed {
    logic neg_i;
    logic neg_q;
  } qpsk_sign_t;

  // Gray rule: the later bit of the pair sets the real sign, the earlier bit the imaginary sign
  function automatic qpsk_sign_t gray_signs(input logic b_first, input logic b_second);
    qpsk_sign_t s;
    s.neg_i = b_second;
    s.neg_q = b_first;
    return s;
  endfunction

  function automatic logic signed [31:0] signed_level(input logic neg, input int amp);
    return neg ? -amp : amp;
  endfunction

  function automatic logic in_band(input int bin, input int lo, input int hi);
    return (bin >= lo) && (bin <= hi);
  endfunction

endpackage

// File: rtl/ofdm_bit_collector.sv
module ofdm_bit_collector #(
  parameter int N_BITS = 96,
  localparam int CNT_W = $clog2(N_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  output logic [N_BITS-1:0] bits
);
  logic [CNT_W-1:0] cnt_q;
  logic [N_BITS-1:0] bits_q;
  logic accept;

  assign full     = (cnt_q == CNT_W'(N_BITS));
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;
  assign count    = cnt_q;
  assign bits     = bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (take) begin
      cnt_q <= '0;
    end else if (accept) begin
      bits_q[cnt_q] <= in_bit;
      cnt_q         <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ofdm_bin_mapper.sv
module ofdm_bin_mapper
  import ofdm_sym_pkg::*;
#(
  parameter int N_BINS   = 64,
  parameter int N_DATA   = 48,
  parameter int N_PILOT  = 7,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 5793,
  parameter int GUARD_LO = 28,
  parameter int GUARD_HI = 35,
  parameter logic [N_PILOT*8-1:0] PILOT_BINS = 56'h0,
  parameter logic [N_PILOT-1:0]   PILOT_NEG  = '0,
  localparam int BIN_W = $clog2(N_BINS),
  localparam int D_W   = $clog2(N_DATA),
  localparam int N_BITS = 2 * N_DATA,
  localparam int CNT_W = $clog2(N_BITS + 1)
) (
  input  logic [BIN_W-1:0]           bin,
  input  logic [D_W-1:0]             didx,
  input  logic [N_BITS-1:0]          sym,
  output logic                       is_data,
  output logic                       is_pilot,
  output logic signed [SAMPLE_W-1:0] samp_i,
  output logic signed [SAMPLE_W-1:0] samp_q
);
  logic       is_null;
  logic       chip_neg;
  logic [CNT_W-1:0] base;
  qpsk_sign_t sg;

  always_comb begin
    is_pilot = 1'b0;
    chip_neg = 1'b0;
    for (int k = 0; k < N_PILOT; k++) begin
      if (int'(bin) == int'(PILOT_BINS[k*8 +: 8])) begin
        is_pilot = 1'b1;
        chip_neg = PILOT_NEG[k];
      end
    end
    is_null = (bin == '0) || in_band(int'(bin), GUARD_LO, GUARD_HI);
    is_data = !is_null && !is_pilot;
  end

  assign base = {{(CNT_W-D_W){1'b0}}, didx} << 1;
  assign sg   = gray_signs(sym[base], sym[base + 1'b1]);

  always_comb begin
    samp_i = '0;
    samp_q = '0;
    if (is_pilot) begin
      samp_i = SAMPLE_W'(signed_level(chip_neg, AMP));
    end else if (is_data) begin
      samp_i = SAMPLE_W'(signed_level(sg.neg_i, AMP));
      samp_q = SAMPLE_W'(signed_level(sg.neg_q, AMP));
    end
  end
endmodule

// File: rtl/ofdm_bin_sequencer.sv
module ofdm_bin_sequencer #(
  parameter int N_BINS = 64,
  parameter int N_DATA = 48,
  localparam int BIN_W  = $clog2(N_BINS),
  localparam int D_W    = $clog2(N_DATA),
  localparam int N_BITS = 2 * N_DATA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full,
  input  logic [N_BITS-1:0] bits_in,
  input  logic              out_ready,
  input  logic              cur_is_data,
  output logic              busy,
  output logic              load,
  output logic              fire,
  output logic              last_fire,
  output logic [BIN_W-1:0]  bin,
  output logic [D_W-1:0]    didx,
  output logic [N_BITS-1:0] sym
);
  logic              busy_q;
  logic [BIN_W-1:0]  bin_q;
  logic [D_W-1:0]    didx_q;
  logic [N_BITS-1:0] sym_q;

  assign busy      = busy_q;
  assign bin       = bin_q;
  assign didx      = didx_q;
  assign sym       = sym_q;
  assign fire      = busy_q && out_ready;
  assign last_fire = fire && (bin_q == BIN_W'(N_BINS - 1));
  assign load      = full && (!busy_q || last_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bin_q  <= '0;
      didx_q <= '0;
      sym_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      bin_q  <= '0;
      didx_q <= '0;
      sym_q  <= bits_in;
    end else if (last_fire) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      bin_q <= bin_q + 1'b1;
      if (cur_is_data) didx_q <= didx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ofdm_sym_builder.sv
module ofdm_sym_builder #(
  parameter int N_BINS   = 64,
  parameter int N_DATA   = 48,
  parameter int N_PILOT  = 7,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 5793,
  parameter int GUARD_LO = 28,
  parameter int GUARD_HI = 35,
  parameter logic [N_PILOT*8-1:0] PILOT_BINS =
    {8'd54, 8'd46, 8'd38, 8'd26, 8'd20, 8'd12, 8'd4},
  parameter logic [N_PILOT-1:0]   PILOT_NEG  = 7'b1011000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_bit,
  output logic                       in_ready,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q,
  output logic                       out_sos
);
  localparam int N_BITS = 2 * N_DATA;
  localparam int BIN_W  = $clog2(N_BINS);
  localparam int D_W    = $clog2(N_DATA);
  localparam int CNT_W  = $clog2(N_BITS + 1);

  // Named internal events, also observed by the checker
  logic              sym_full;
  logic              load_evt;
  logic              out_fire;
  logic              last_fire;
  logic              is_data;
  logic              is_pilot;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BIN_W-1:0]  bin_idx;
  logic [D_W-1:0]    data_idx;
  logic [N_BITS-1:0] col_bits;
  logic [N_BITS-1:0] cur_sym;
  logic              busy;

  ofdm_bit_collector #(.N_BITS(N_BITS)) u_col (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .take(load_evt), .full(sym_full),
    .count(bit_cnt), .bits(col_bits)
  );

  ofdm_bin_sequencer #(.N_BINS(N_BINS), .N_DATA(N_DATA)) u_seq (
    .clk(clk), .rst_n(rst_n), .full(sym_full), .bits_in(col_bits),
    .out_ready(out_ready), .cur_is_data(is_data), .busy(busy),
    .load(load_evt), .fire(out_fire), .last_fire(last_fire),
    .bin(bin_idx), .didx(data_idx), .sym(cur_sym)
  );

  ofdm_bin_mapper #(
    .N_BINS(N_BINS), .N_DATA(N_DATA), .N_PILOT(N_PILOT), .SAMPLE_W(SAMPLE_W),
    .AMP(AMP), .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI),
    .PILOT_BINS(PILOT_BINS), .PILOT_NEG(PILOT_NEG)
  ) u_map (
    .bin(bin_idx), .didx(data_idx), .sym(cur_sym),
    .is_data(is_data), .is_pilot(is_pilot),
    .samp_i(out_i), .samp_q(out_q)
  );

  assign out_valid = busy;
  assign out_sos   = busy && (bin_idx == '0);
endmodule

// File: rtl/ofdm_sym_builder_chk.sv
module ofdm_sym_builder_chk #(
  parameter int N_BINS   = 64,
  parameter int N_DATA   = 48,
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 5793,
  parameter int BIN_W    = 6,
  parameter int D_W      = 6,
  parameter int CNT_W    = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic signed [SAMPLE_W-1:0] out_i,
  input logic signed [SAMPLE_W-1:0] out_q,
  input logic                       out_sos,
  input logic                       load_evt,
  input logic                       out_fire,
  input logic                       last_fire,
  input logic                       is_data,
  input logic                       is_pilot,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic [BIN_W-1:0]           bin_idx,
  input logic [D_W-1:0]             data_idx
);
  localparam logic signed [SAMPLE_W-1:0] LVL_P = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] LVL_N = SAMPLE_W'(-AMP);

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> bit_cnt < CNT_W'(2 * N_DATA)); // R2
  AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !last_fire |=> out_valid && bin_idx == $past(bin_idx) + 1'b1); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q) && $stable(out_sos)); // R4
  AST_QPSK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_data |-> (out_i == LVL_P || out_i == LVL_N) && (out_q == LVL_P || out_q == LVL_N)); // R5
  AST_DATA_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |-> is_data && data_idx == D_W'(N_DATA - 1)); // R6
  AST_PILOT_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_pilot |-> out_q == '0 && (out_i == LVL_P || out_i == LVL_N)); // R7
  AST_DC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sos |-> out_i == '0 && out_q == '0); // R8
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> out_valid && out_sos); // R9
endmodule

bind ofdm_sym_builder ofdm_sym_builder_chk #(
  .N_BINS(N_BINS), .N_DATA(N_DATA), .SAMPLE_W(SAMPLE_W), .AMP(AMP),
  .BIN_W(BIN_W), .D_W(D_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
  .out_sos(out_sos), .load_evt(load_evt), .out_fire(out_fire),
  .last_fire(last_fire), .is_data(is_data), .is_pilot(is_pilot),
  .bit_cnt(bit_cnt), .bin_idx(bin_idx), .data_idx(data_idx)
);

// File: tb/ofdm_sym_builder_tb.sv
module ofdm_sym_builder_tb;
  localparam int A = 5793;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_i, out_q;
  logic out_sos;

  int n_checks = 0;
  int n_errors = 0;

  logic signed [15:0] cap_i [0:127];
  logic signed [15:0] cap_q [0:127];
  logic               cap_s [0:127];

  always #5 clk = ~clk;

  ofdm_sym_builder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .out_sos(out_sos)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench view of the bin plan
  function automatic int pilot_slot(input int b);
    int pb[7] = '{4, 12, 20, 26, 38, 46, 54};
    for (int k = 0; k < 7; k++) if (pb[k] == b) return k;
    return -1;
  endfunction

  function automatic bit null_bin(input int b);
    return b == 0 || (b >= 28 && b <= 35);
  endfunction

  function automatic void expect_bin(input logic [95:0] s, input int b,
                                     output int ei, output int eq, output string req);
    int chip[7] = '{1, 1, 1, -1, -1, 1, -1};
    int ord = 0;
    ei = 0; eq = 0;
    if (null_bin(b)) begin
      req = "R8";
    end else if (pilot_slot(b) >= 0) begin
      req = "R7";
      ei = chip[pilot_slot(b)] * A;
    end else begin
      req = "R5/R6";
      for (int x = 0; x < b; x++) if (!null_bin(x) && pilot_slot(x) < 0) ord++;
      case ({s[2*ord], s[2*ord+1]})
        2'b00: begin ei =  A; eq =  A; end
        2'b01: begin ei = -A; eq =  A; end
        2'b11: begin ei = -A; eq = -A; end
        default: begin ei =  A; eq = -A; end
      endcase
    end
  endfunction

  task automatic push_sym(input logic [95:0] s);
    for (int k = 0; k < 96; k++) begin
      do begin
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = s[k];
        #1;
      end while (!in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic capture(input int n, input bit stall);
    int got = 0;
    int cyc = 0;
    logic held = 1'b0;
    logic signed [15:0] hi, hq;
    logic hs;
    while (got < n) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (held) begin
        check("R4", "held I", out_i, hi);
        check("R4", "held Q", out_q, hq);
        check("R4", "held sos", out_sos, hs);
      end
      held = out_valid && !out_ready;
      hi = out_i; hq = out_q; hs = out_sos;
      if (out_valid && out_ready) begin
        cap_i[got] = out_i;
        cap_q[got] = out_q;
        cap_s[got] = out_sos;
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic verify_sym(input logic [95:0] s, input int base);
    int ei, eq;
    string req;
    for (int b = 0; b < 64; b++) begin
      expect_bin(s, b, ei, eq, req);
      check(req, $sformatf("bin %0d I", b), cap_i[base+b], ei);
      check(req, $sformatf("bin %0d Q", b), cap_q[base+b], eq);
      check("R3", $sformatf("bin %0d sos", b), cap_s[base+b], (b == 0) ? 1 : 0);
    end
  endtask

  task automatic test_reset();
    #1;
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic test_pattern(input logic [95:0] s, input bit stall);
    fork
      push_sym(s);
      capture(64, stall);
    join
    verify_sym(s, 0);
    check("R2", "ready after symbol", in_ready, 1);
    check("R3", "idle after 64 bins", out_valid, 0);
  endtask

  task automatic test_backpressure(input logic [95:0] sa, input logic [95:0] sb);
    out_ready = 1'b0;
    push_sym(sa);
    push_sym(sb);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = 1'b1;
      #1;
      check("R2", "in_ready while full and stalled", in_ready, 0);
      check("R4", "bin 0 still offered", out_sos, 1);
    end
    in_valid = 1'b0;
    capture(128, 1'b0);
    verify_sym(sa, 0);
    verify_sym(sb, 64);
    check("R9", "idle after two symbols", out_valid, 0);
  endtask

  function automatic logic [95:0] gray_cycle();
    logic [95:0] s;
    logic [1:0] pat[4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    for (int d = 0; d < 48; d++) begin
      s[2*d]   = pat[d%4][1];
      s[2*d+1] = pat[d%4][0];
    end
    return s;
  endfunction

  function automatic logic [95:0] lfsr_bits(input logic [15:0] seed);
    logic [95:0] s;
    logic [15:0] r = seed;
    for (int k = 0; k < 96; k++) begin
      s[k] = r[0];
      r = {r[0] ^ r[2] ^ r[3] ^ r[5], r[15:1]};
    end
    return s;
  endfunction

  initial begin
    #(200000 * 10);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_pattern('0, 1'b0);
    test_pattern('1, 1'b0);
    test_pattern(gray_cycle(), 1'b0);
    test_pattern(lfsr_bits(16'hACE1), 1'b1);
    test_backpressure(lfsr_bits(16'h1D2B), gray_cycle());
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule